// File: doc/BRIEF.md
# Fixed-Priority Interrupt Decoder with Spurious Vector

This block sits between a set of peripheral request sources and a small CPU core. Each peripheral raises its request by pulsing an event line. The pulse sets a sticky flag. An external level-sensitive line is not latched; it is treated as a live request. Each source has its own enable bit, and a global mask input from the CPU condition register gates the single interrupt line toward the core.

When the core takes the interrupt, it later issues a vector-fetch strobe. The decoder does not remember which source caused the interrupt line to rise. It resolves priority again at the strobe, using the flags, the live external line and the enables as they stand at that moment. If a request was withdrawn in the meantime, or its enable was cleared, that source is not answered with its own vector. When nothing qualifying remains, the decoder returns a dedicated spurious vector, placed at the vector base plus 0x1DC.

Software clears flags with write-one-to-clear writes. The same write port loads the enable bits and the vector base.

Top module: `irq_prio_dec`

## Requirements
- R1: A synchronous active-high reset clears all flags and enables, sets `vec_addr` to 0 and `vec_ack` to 0, and restores the vector base to `BASE_RST`.
- R2: `irq` is high exactly when `gmask` is low and at least one source is both active and enabled. Sources are numbered as follows: index 0 is `ext_lvl`, and index k+1 is flag bit k. `irq` follows registered flags, so a flag set by an event is seen on `irq` one cycle later. A change on `gmask` or `ext_lvl` is seen in the same cycle.
- R3: At a fetch, the active enabled source with the lowest index wins. Its vector is the base minus four times its index. `gmask` does not take part in this choice.
- R4: If no enabled source is active at the cycle of `vec_fetch`, the fetched address is the base plus 0x1DC.
- R5: The fetched address appears on `vec_addr` one cycle after `vec_fetch` and holds until the next strobe. `vec_ack` is high for exactly the cycle after each strobe.
- R6: A write with `wr_sel`=0 clears each flag whose bit in `wr_data` is one. Flags whose bits are written as zero keep their value.
- R7: Writing back with `wr_sel`=0 the value read from `flags_o` clears every flag that was set.
- R8: An event on `src_evt` in the same cycle as a clear write to the same bit leaves that flag set.
- R9: If the only pending source has its enable cleared (`wr_sel`=1 loads the enables from `wr_data[NUM_SRC:0]`) before the fetch, the fetch returns the spurious vector. If a lower-priority source is still enabled, that source's vector is returned instead.
- R10: A pulse on `ext_lvl` that ends before `vec_fetch` yields the spurious vector.
- R11: A write with `wr_sel`=2 loads the vector base from `wr_data`. Later source and spurious vectors are computed from the new base. `wr_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | NUM_SRC | Peripheral set events, one per flag |
| ext_lvl | input | 1 | Level-sensitive external request (source index 0) |
| gmask | input | 1 | Global interrupt mask from the CPU |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 flag clear, 1 enables, 2 base, 3 none |
| wr_data | input | ADDR_W | Write data |
| vec_fetch | input | 1 | Vector-fetch strobe from the CPU |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | ADDR_W | Registered vector address |
| vec_ack | output | 1 | One-cycle pulse with each fetched address |
| flags_o | output | NUM_SRC | Current flag register |

## Verification
The bench builds the block with NUM_SRC=6, ADDR_W=16 and BASE_RST=0xFE00. This gives seven prioritised sources, whose vectors run from 0xFE00 down to 0xFDE8, and a spurious vector at 0xFFDC. A 16-bit base is small enough to follow by hand. With seven sources, the bench can set a request at both ends of the priority order and leave a lower-priority source enabled behind a disabled one. Reloading the base to 0x8000 checks that the source vectors and the spurious vector both follow the base, and that neither wraps past a 16-bit carry.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SEL_FLAG_CLR = 2'd0,
    SEL_ENABLE   = 2'd1,
    SEL_BASE     = 2'd2,
    SEL_NONE     = 2'd3
  } wsel_e;

  localparam logic [31:0] SPUR_OFS = 32'h0000_01DC;

  // vector of a winning source: base minus four per index step
  function automatic logic [31:0] vec_calc(input logic [31:0] base,
                                           input logic [31:0] idx);
    return base - (idx << 2);
  endfunction

  // vector answered when no qualifying source remains
  function automatic logic [31:0] spur_calc(input logic [31:0] base);
    return base + SPUR_OFS;
  endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)
          flags_q[i] <= 1'b0;
        else if (set_i[i])
          flags_q[i] <= 1'b1;       // event wins over a same-cycle clear
        else if (clr_i[i])
          flags_q[i] <= 1'b0;
      end
    end
  endgenerate

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_pkg::*;
#(
  parameter int          S        = 9,
  parameter int          AW       = 16,
  parameter logic [AW-1:0] BASE_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  wsel_e         wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [S-1:0]  en_o,
  output logic [AW-1:0] base_o
);
  logic [S-1:0]  en_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      base_q <= BASE_RST;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_ENABLE: en_q   <= wr_data[S-1:0];
        SEL_BASE:   base_q <= wr_data;
        default:    ;
      endcase
    end
  end

  assign en_o   = en_q;
  assign base_o = base_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int S  = 9,
  localparam int IW = (S > 1) ? $clog2(S) : 1
) (
  input  logic [S-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // chain of "something below already won" terms, lowest index first
  logic [S:0]   taken;
  logic [S-1:0] grant;

  assign taken[0] = 1'b0;
  generate
    for (genvar i = 0; i < S; i++) begin : g_chain
      assign grant[i]   = req_i[i] & ~taken[i];
      assign taken[i+1] = taken[i] | req_i[i];
    end
  endgenerate

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < S; i++)
      if (grant[i]) idx_o = IW'(i);
  end

  assign valid_o = taken[S];
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_i,
  input  logic [AW-1:0] addr_d_i,
  output logic [AW-1:0] addr_o,
  output logic          ack_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o <= '0;
      ack_o  <= 1'b0;
    end else begin
      ack_o <= fetch_i;
      if (fetch_i) addr_o <= addr_d_i;
    end
  end
endmodule

// File: rtl/irq_prio_dec.sv
module irq_prio_dec
  import irq_pkg::*;
#(
  parameter int            NUM_SRC  = 8,
  parameter int            ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] BASE_RST = 16'hFE00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               ext_lvl,
  input  logic               gmask,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               vec_fetch,
  output logic               irq,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               vec_ack,
  output logic [NUM_SRC-1:0] flags_o
);
  localparam int S  = NUM_SRC + 1;
  localparam int IW = (S > 1) ? $clog2(S) : 1;

  wsel_e              sel;
  logic [NUM_SRC-1:0] clr_hit;
  logic [S-1:0]       en;
  logic [ADDR_W-1:0]  base;
  logic [S-1:0]       live_req;
  logic               pick_valid;
  logic [IW-1:0]      pick_idx;
  logic [ADDR_W-1:0]  src_addr;
  logic [ADDR_W-1:0]  spur_addr;
  logic [ADDR_W-1:0]  next_addr;

  assign sel     = wsel_e'(wr_sel);
  assign clr_hit = (wr_en && sel == SEL_FLAG_CLR) ? wr_data[NUM_SRC-1:0] : '0;

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_i   (src_evt),
    .clr_i   (clr_hit),
    .flags_o (flags_o)
  );

  irq_cfg_regs #(.S(S), .AW(ADDR_W), .BASE_RST(BASE_RST)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (sel),
    .wr_data (wr_data),
    .en_o    (en),
    .base_o  (base)
  );

  // index 0: live external line; index k+1: flag k
  assign live_req = {flags_o, ext_lvl} & en;
  assign irq      = (|live_req) & ~gmask;

  irq_prio_pick #(.S(S)) u_pick (
    .req_i   (live_req),
    .valid_o (pick_valid),
    .idx_o   (pick_idx)
  );

  assign src_addr  = ADDR_W'(vec_calc(32'(base), 32'(pick_idx)));
  assign spur_addr = ADDR_W'(spur_calc(32'(base)));
  assign next_addr = pick_valid ? src_addr : spur_addr;

  irq_vec_reg #(.AW(ADDR_W)) u_vec (
    .clk      (clk),
    .rst      (rst),
    .fetch_i  (vec_fetch),
    .addr_d_i (next_addr),
    .addr_o   (vec_addr),
    .ack_o    (vec_ack)
  );
endmodule

// File: rtl/irq_prio_dec_chk.sv
module irq_prio_dec_chk #(
  parameter int N  = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          gmask,
  input logic          irq,
  input logic          vec_fetch,
  input logic          vec_ack,
  input logic [AW-1:0] vec_addr,
  input logic [N-1:0]  src_evt,
  input logic [N-1:0]  flags,
  input logic [N-1:0]  clr_hit,
  input logic          pick_valid,
  input logic [AW-1:0] spur_addr
);
  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    gmask |-> !irq);

  a_r2_irq_has_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> pick_valid);

  a_r5_ack_after_fetch: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> vec_ack);

  a_r5_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !vec_fetch |=> !vec_ack);

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !vec_fetch |=> $stable(vec_addr));

  a_r4_spurious_when_empty: assert property (@(posedge clk) disable iff (rst)
    (vec_fetch && !pick_valid) |=> (vec_addr == $past(spur_addr)));

  a_r8_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt)));

  a_r6_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|(clr_hit & ~src_evt)) |=> ((flags & $past(clr_hit & ~src_evt)) == '0));

  a_r6_no_rise_without_event: assert property (@(posedge clk) disable iff (rst)
    (src_evt == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

bind irq_prio_dec irq_prio_dec_chk #(.N(NUM_SRC), .AW(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gmask      (gmask),
  .irq        (irq),
  .vec_fetch  (vec_fetch),
  .vec_ack    (vec_ack),
  .vec_addr   (vec_addr),
  .src_evt    (src_evt),
  .flags      (flags_o),
  .clr_hit    (clr_hit),
  .pick_valid (pick_valid),
  .spur_addr  (spur_addr)
);

// File: tb/sim_irq_prio_dec.sv
module sim_irq_prio_dec;
  localparam int          NS  = 6;
  localparam int          AW  = 16;
  localparam logic [15:0] B0  = 16'hFE00;
  localparam logic [15:0] SPU = 16'hFFDC;   // B0 + 0x1DC

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_evt = '0;
  logic          ext_lvl = 1'b0;
  logic          gmask = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd3;
  logic [AW-1:0] wr_data = '0;
  logic          vec_fetch = 1'b0;
  logic          irq;
  logic [AW-1:0] vec_addr;
  logic          vec_ack;
  logic [NS-1:0] flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_prio_dec #(.NUM_SRC(NS), .ADDR_W(AW), .BASE_RST(B0)) u0 (
    .clk(clk), .rst(rst), .src_evt(src_evt), .ext_lvl(ext_lvl),
    .gmask(gmask), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_fetch(vec_fetch), .irq(irq), .vec_addr(vec_addr),
    .vec_ack(vec_ack), .flags_o(flags_o)
  );

  // row: evt[31:26] en[25:19] ext[18] gmask[17] exp_irq[16] exp_addr[15:0]
  localparam logic [31:0] TBL [0:5] = '{
    {6'h01, 7'h7F, 1'b0, 1'b0, 1'b1, 16'hFDFC},  // flag0 -> idx1
    {6'h30, 7'h7F, 1'b0, 1'b0, 1'b1, 16'hFDEC},  // flags4,5 -> idx5
    {6'h30, 7'h5F, 1'b0, 1'b0, 1'b1, 16'hFDE8},  // idx5 disabled -> idx6
    {6'h00, 7'h01, 1'b1, 1'b0, 1'b1, 16'hFE00},  // external held -> idx0
    {6'h02, 7'h7F, 1'b0, 1'b1, 1'b0, 16'hFDF8},  // masked line, fetch idx2
    {6'h04, 7'h00, 1'b0, 1'b0, 1'b0, 16'hFFDC}   // nothing enabled
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    step();
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic fetch();
    vec_fetch = 1'b1;
    step();
    vec_fetch = 1'b0;
  endtask

  task automatic pulse(input logic [NS-1:0] e);
    src_evt = e;
    step();
    src_evt = '0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] rd;
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R1 reset state
    chk(flags_o == '0, "R1 flags", 32'(flags_o), 0);
    chk(irq == 1'b0,   "R1 irq", 32'(irq), 0);
    chk(vec_ack == 1'b0 && vec_addr == '0, "R1 vec", 32'(vec_addr), 0);

    // table walk: R2/R3/R4/R5
    for (int r = 0; r < 6; r++) begin
      logic [31:0] row;
      row = TBL[r];
      wr(2'd0, 16'h003F);
      wr(2'd1, {9'b0, row[25:19]});
      ext_lvl = row[18]; gmask = row[17];
      pulse(row[31:26]);
      chk(irq == row[16], $sformatf("R2 row%0d irq", r), 32'(irq), 32'(row[16]));
      fetch();
      chk(vec_ack == 1'b1, $sformatf("R5 row%0d ack", r), 32'(vec_ack), 1);
      chk(vec_addr == row[15:0], $sformatf("R3 row%0d addr", r),
          32'(vec_addr), 32'(row[15:0]));
      step();
      chk(vec_ack == 1'b0, $sformatf("R5 row%0d ack drop", r), 32'(vec_ack), 0);
      ext_lvl = 1'b0; gmask = 1'b0;
    end

    // R3: external line beats every flag
    wr(2'd0, 16'h003F); wr(2'd1, 16'h007F);
    ext_lvl = 1'b1;
    pulse(6'h3F);
    fetch();
    chk(vec_addr == B0, "R3 ext wins", 32'(vec_addr), 32'(B0));
    ext_lvl = 1'b0;

    // R2 gmask seen in same cycle
    gmask = 1'b1; #1;
    chk(irq == 1'b0, "R2 gmask low irq", 32'(irq), 0);
    gmask = 1'b0; #1;
    chk(irq == 1'b1, "R2 gmask release", 32'(irq), 1);

    // R6 single-bit clear
    wr(2'd0, 16'h003F);
    pulse(6'h0F);
    wr(2'd0, 16'h0008);
    chk(flags_o == 6'h07, "R6 w1c bit3", 32'(flags_o), 32'h07);

    // R7 read-modify-write clears all
    pulse(6'h28);
    rd = flags_o;
    chk(rd == 6'h2F, "R7 pre", 32'(rd), 32'h2F);
    wr(2'd0, {10'b0, rd});
    chk(flags_o == '0, "R7 rmw clears all", 32'(flags_o), 0);

    // R8 event wins over simultaneous clear
    pulse(6'h01);
    src_evt = 6'h02;
    wr(2'd0, 16'h0003);
    src_evt = '0; #1;
    chk(flags_o == 6'h02, "R8 set beats clear", 32'(flags_o), 32'h02);

    // R9 enable cleared before fetch
    wr(2'd0, 16'h003F); wr(2'd1, 16'h007F);
    pulse(6'h04);
    chk(irq == 1'b1, "R9 pending", 32'(irq), 1);
    wr(2'd1, 16'h0000);
    chk(irq == 1'b0, "R9 irq drops", 32'(irq), 0);
    fetch();
    chk(vec_addr == SPU, "R9 spurious", 32'(vec_addr), 32'(SPU));
    wr(2'd1, 16'h007F);
    pulse(6'h20);
    wr(2'd1, 16'h0077);            // idx3 off, idx6 still on
    fetch();
    chk(vec_addr == 16'hFDE8, "R9 lower remains", 32'(vec_addr), 32'hFDE8);

    // R10 short external pulse
    wr(2'd0, 16'h003F); wr(2'd1, 16'h0001);
    ext_lvl = 1'b1; step();
    chk(irq == 1'b1, "R10 pulse seen", 32'(irq), 1);
    ext_lvl = 1'b0; step();
    fetch();
    chk(vec_addr == SPU, "R10 spurious", 32'(vec_addr), 32'(SPU));

    // R5 hold between strobes
    wr(2'd1, 16'h007F);
    pulse(6'h01);
    repeat (3) step();
    chk(vec_addr == SPU, "R5 hold", 32'(vec_addr), 32'(SPU));

    // R11 base reload, and no-op select
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'h8000);
    fetch();
    chk(vec_addr == 16'h7FFC, "R11 src from new base", 32'(vec_addr), 32'h7FFC);
    wr(2'd0, 16'h003F);
    fetch();
    chk(vec_addr == 16'h81DC, "R11 spurious new base", 32'(vec_addr), 32'h81DC);
    chk(flags_o == '0, "R11 sel3 no effect", 32'(flags_o), 0);

    // R1 mid-run reset restores base and clears enables
    pulse(6'h3F);
    rst = 1'b1; step(); rst = 1'b0; #1;
    chk(flags_o == '0 && vec_addr == '0, "R1 rerun", 32'(flags_o), 0);
    pulse(6'h01);
    chk(irq == 1'b0, "R1 enables cleared", 32'(irq), 0);
    fetch();
    chk(vec_addr == SPU, "R1 base default", 32'(vec_addr), 32'(SPU));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule